// File: doc/BRIEF.md
# RTC Power-On Status Register Bank

This block holds the configuration and status registers of a real-time-clock control section. Its main job is to catch a power-on event. A pulse on `por_evt_i` raises a sticky power-on flag. The same pulse also returns the trim register, the first control register and most of the status register to zero. Software must then write the flag back to 0 before it can trust the rest of the clock. The block also keeps two more sticky indications. An oscillator-good bit falls when the oscillator stops. A supply-drop flag rises when the voltage detector fires.

Software reaches the registers through a plain synchronous port: a 4-bit address, a write strobe, write data and a combinational read path. Three addresses are mapped. Address 7 holds the 7-bit trim value. Address 14 holds the first control register. Address 15 holds the status register. The interrupt output enable stays low while the power-on flag is set.

Top module: `rtc_por_regs`

## Requirements
- R1: While reset is applied and after it is released, the block behaves as if a power-on event had occurred. The status register reads 0x10 (power-on flag at bit 4 set, oscillator-good bit 5 at its reset value 0). Addresses 7 and 14 read 0x00 and `irq_oe_o` is 0.
- R2: A cycle with `por_evt_i` high sets status bit 4 at the next clock edge. The bit then stays 1 until a write to address 15 carries 0 in bit 4.
- R3: A cycle with `por_evt_i` high has these effects at the next edge. Address 7 and address 14 become 0x00. Status bits 7, 3, 2, 1 and 0 become 0. Status bit 6 becomes 0 unless `vdrop_i` is high in the same cycle. Status bit 5 keeps the value it would otherwise take.
- R4: A write to address 15 with bit 4 = 1 leaves the power-on flag unchanged. A write with bit 4 = 0 clears it.
- R5: When a write that clears the power-on flag arrives in the same cycle as `por_evt_i`, the flag stays 1. The same-cycle write has no effect on the cleared registers.
- R6: `osc_stop_i` clears status bit 5 at the next edge. The bit stays 0 until a write to address 15 sets bit 5 to 1. If `osc_stop_i` and such a write arrive in the same cycle, `osc_stop_i` wins.
- R7: `vdrop_i` sets status bit 6 at the next edge. Writing 1 to bit 6 has no effect. Writing 0 clears it unless `vdrop_i` is high in the same cycle.
- R8: At address 7, bit 7 always reads 0 and bits 6:0 take the written value.
- R9: All eight bits of address 14 are read/write. Status bits 7, 3, 2, 1 and 0 take the written value.
- R10: A read of any address other than 7, 14 and 15 returns 0x00. A write to such an address changes no register.
- R11: `irq_oe_o` is 1 exactly when status bit 4 is 0 and at least one of the alarm-enable bits (address 14, bits 7 and 6) is 1. The output follows in the same cycle.
- R12: `rd_data_o` shows the addressed register in the same cycle. The three register outputs always match the readable contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, treated as power-up |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` |
| por_evt_i | input | 1 | Power-on event pulse |
| osc_stop_i | input | 1 | Oscillator stop indication |
| vdrop_i | input | 1 | Supply voltage drop indication |
| trim_q_o | output | 8 | Trim register contents (address 7) |
| ctl_q_o | output | 8 | First control register contents (address 14) |
| stat_q_o | output | 8 | Status register contents (address 15) |
| irq_oe_o | output | 1 | Interrupt output enable; 0 means the outputs float |

## Verification
The power-on clear is tried in three settings. In the first, the power-on pulse arrives alone after every register holds non-zero data, which shows which bits it clears and which survive. In the second, it arrives together with a write that would clear the flag, which shows the priority between the two. In the third, the oscillator-good bit is low, which shows that the pulse keeps bit 5 as it is rather than setting it. The two sticky indications are each driven alone and then together with a same-cycle write, to show that the hardware event beats software. Writes of 1 to the clear-only bits, and reads and writes of unmapped addresses, show the bits that must not move. The interrupt enable is followed through every change of the flag and of the alarm-enable bits.

// File: rtl/rtc_por_pkg.sv
package rtc_por_pkg;
   localparam int REG_W     = 8;
   localparam int BIT_VSEL  = 7;
   localparam int BIT_VFLAG = 6;
   localparam int BIT_OSCOK = 5;
   localparam int BIT_POR   = 4;
   localparam int BIT_WKEN  = 7;
   localparam int BIT_DAYEN = 6;

   typedef struct packed {
      logic       volt_sel;
      logic       volt_flag;
      logic       osc_ok;
      logic       por_flag;
      logic       fout_off;
      logic [2:0] evt_flags;
   } stat_t;
endpackage

// File: rtl/rtc_por_decode.sv
module rtc_por_decode #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int A_TRIM = 7,
   parameter int A_CTL  = 14,
   parameter int A_STAT = 15
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] trim_q_i,
   input  logic [DATA_W-1:0] ctl_q_i,
   input  logic [DATA_W-1:0] stat_q_i,
   output logic              we_trim_o,
   output logic              we_ctl_o,
   output logic              we_stat_o,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam logic [ADDR_W-1:0] AT = ADDR_W'(A_TRIM);
   localparam logic [ADDR_W-1:0] AC = ADDR_W'(A_CTL);
   localparam logic [ADDR_W-1:0] AS = ADDR_W'(A_STAT);

   logic hit_t, hit_c, hit_s;

   assign hit_t = (addr_i == AT);
   assign hit_c = (addr_i == AC);
   assign hit_s = (addr_i == AS);

   assign we_trim_o = wr_en_i && hit_t;
   assign we_ctl_o  = wr_en_i && hit_c;
   assign we_stat_o = wr_en_i && hit_s;

   always_comb begin
      rd_data_o = '0;
      if (hit_t)      rd_data_o = trim_q_i;
      else if (hit_c) rd_data_o = ctl_q_i;
      else if (hit_s) rd_data_o = stat_q_i;
   end
endmodule

// File: rtl/rtc_por_cfg.sv
module rtc_por_cfg #(
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] WR_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wd_i,
   output logic [DATA_W-1:0] q_o
);
   logic [DATA_W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_r <= '0;
      else if (clr_i) q_r <= '0;
      else if (we_i)  q_r <= wd_i & WR_MASK;
   end

   assign q_o = q_r;

   assert_cfg_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (q_o == '0));

   assert_cfg_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !clr_i) |=> (q_o == ($past(wd_i) & WR_MASK)));
endmodule

// File: rtl/rtc_por_stat.sv
module rtc_por_stat
   import rtc_por_pkg::*;
#(
   parameter bit OSC_OK_RST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_evt_i,
   input  logic             osc_stop_i,
   input  logic             vdrop_i,
   input  logic             we_i,
   input  logic [REG_W-1:0] wd_i,
   output logic [REG_W-1:0] q_o
);
   stat_t st, st_d;

   always_comb begin
      st_d = st;
      if (we_i) begin
         st_d.volt_sel  = wd_i[BIT_VSEL];
         if (!wd_i[BIT_VFLAG]) st_d.volt_flag = 1'b0;
         st_d.osc_ok    = wd_i[BIT_OSCOK];
         if (!wd_i[BIT_POR])   st_d.por_flag  = 1'b0;
         st_d.fout_off  = wd_i[3];
         st_d.evt_flags = wd_i[2:0];
      end
      if (por_evt_i) begin
         st_d.volt_sel  = 1'b0;
         st_d.volt_flag = 1'b0;
         st_d.por_flag  = 1'b1;
         st_d.fout_off  = 1'b0;
         st_d.evt_flags = '0;
      end
      if (vdrop_i)    st_d.volt_flag = 1'b1;
      if (osc_stop_i) st_d.osc_ok    = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= '0;
         st.por_flag <= 1'b1;
         st.osc_ok   <= OSC_OK_RST;
      end else begin
         st <= st_d;
      end
   end

   assign q_o = st;

   assert_por_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      por_evt_i |=> q_o[BIT_POR]);

   assert_por_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[BIT_POR] && !(we_i && !wd_i[BIT_POR])) |=> q_o[BIT_POR]);

   assert_por_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !wd_i[BIT_POR] && !por_evt_i) |=> !q_o[BIT_POR]);

   assert_stat_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (por_evt_i && !vdrop_i) |=> (q_o[7:6] == 2'b00 && q_o[3:0] == 4'h0));

   assert_osc_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      osc_stop_i |=> !q_o[BIT_OSCOK]);

   assert_osc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_o[BIT_OSCOK] && !(we_i && wd_i[BIT_OSCOK])) |=> !q_o[BIT_OSCOK]);

   assert_vflag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vdrop_i |=> q_o[BIT_VFLAG]);
endmodule

// File: rtl/rtc_por_regs.sv
module rtc_por_regs
   import rtc_por_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 8,
   parameter int A_TRIM     = 7,
   parameter int A_CTL      = 14,
   parameter int A_STAT     = 15,
   parameter bit OSC_OK_RST = 1'b0,
   parameter bit OE_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              por_evt_i,
   input  logic              osc_stop_i,
   input  logic              vdrop_i,
   output logic [DATA_W-1:0] trim_q_o,
   output logic [DATA_W-1:0] ctl_q_o,
   output logic [DATA_W-1:0] stat_q_o,
   output logic              irq_oe_o
);
   localparam int                NADDR     = 2 ** ADDR_W;
   localparam logic [DATA_W-1:0] TRIM_MASK = {1'b0, {(DATA_W-1){1'b1}}};

   initial begin
      if (DATA_W != REG_W)
         $fatal(1, "rtc_por_regs: DATA_W must equal %0d", REG_W);
      if (A_TRIM >= NADDR || A_CTL >= NADDR || A_STAT >= NADDR)
         $fatal(1, "rtc_por_regs: register address outside address space");
      if (A_TRIM == A_CTL || A_TRIM == A_STAT || A_CTL == A_STAT)
         $fatal(1, "rtc_por_regs: register addresses must differ");
   end

   logic we_trim, we_ctl, we_stat;
   logic alarm_en;

   rtc_por_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .A_TRIM(A_TRIM), .A_CTL(A_CTL), .A_STAT(A_STAT)
   ) u_dec (
      .addr_i    (addr_i),
      .wr_en_i   (wr_en_i),
      .trim_q_i  (trim_q_o),
      .ctl_q_i   (ctl_q_o),
      .stat_q_i  (stat_q_o),
      .we_trim_o (we_trim),
      .we_ctl_o  (we_ctl),
      .we_stat_o (we_stat),
      .rd_data_o (rd_data_o)
   );

   rtc_por_cfg #(.DATA_W(DATA_W), .WR_MASK(TRIM_MASK)) u_trim (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (por_evt_i),
      .we_i  (we_trim),
      .wd_i  (wr_data_i),
      .q_o   (trim_q_o)
   );

   rtc_por_cfg #(.DATA_W(DATA_W), .WR_MASK('1)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (por_evt_i),
      .we_i  (we_ctl),
      .wd_i  (wr_data_i),
      .q_o   (ctl_q_o)
   );

   rtc_por_stat #(.OSC_OK_RST(OSC_OK_RST)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .por_evt_i  (por_evt_i),
      .osc_stop_i (osc_stop_i),
      .vdrop_i    (vdrop_i),
      .we_i       (we_stat),
      .wd_i       (wr_data_i),
      .q_o        (stat_q_o)
   );

   assign alarm_en = ctl_q_o[BIT_WKEN] | ctl_q_o[BIT_DAYEN];

   generate
      if (OE_REG) begin : g_oe_reg
         logic oe_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         oe_r <= 1'b0;
            else if (por_evt_i) oe_r <= 1'b0;
            else                oe_r <= !stat_q_o[BIT_POR] && alarm_en;
         end
         assign irq_oe_o = oe_r;
      end else begin : g_oe_comb
         assign irq_oe_o = !stat_q_o[BIT_POR] && alarm_en;
      end
   endgenerate

   assert_oe_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_oe_o |-> !stat_q_o[BIT_POR]);

   assert_por_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (por_evt_i && we_stat && !wr_data_i[BIT_POR]) |=> stat_q_o[BIT_POR]);

   assert_trim_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      we_trim |=> !trim_q_o[DATA_W-1]);
endmodule

// File: tb/rtc_por_regs_bench.sv
`timescale 1ns/1ps
module rtc_por_regs_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       por_evt = 1'b0, osc_stop = 1'b0, vdrop = 1'b0;
   logic [7:0] trim_q, ctl_q, stat_q;
   logic       irq_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int         sel;
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sb_q[$];

   always #2 clk = ~clk;

   rtc_por_regs u_rtc_por_regs (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
      .wr_data_i(wr_data), .rd_data_o(rd_data), .por_evt_i(por_evt),
      .osc_stop_i(osc_stop), .vdrop_i(vdrop), .trim_q_o(trim_q),
      .ctl_q_o(ctl_q), .stat_q_o(stat_q), .irq_oe_o(irq_oe)
   );

   // sel: 0 rd_data, 1 irq_oe, 2 trim_q, 3 ctl_q, 4 stat_q
   always @(negedge clk) begin
      #1;
      while (sb_q.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it = sb_q.pop_front();
         case (it.sel)
            0: act = rd_data;
            1: act = {7'd0, irq_oe};
            2: act = trim_q;
            3: act = ctl_q;
            default: act = stat_q;
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic op(input logic [3:0] a, input logic we, input logic [7:0] d,
                     input logic pe, input logic os, input logic vd);
      @(negedge clk);
      addr = a; wr_en = we; wr_data = d;
      por_evt = pe; osc_stop = os; vdrop = vd;
      @(posedge clk);
      #1;
      wr_en = 1'b0; por_evt = 1'b0; osc_stop = 1'b0; vdrop = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      op(a, 1'b1, d, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      item_t it;
      @(negedge clk);
      addr = a; wr_en = 1'b0;
      it.sel = 0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic port(input int s, input logic [7:0] e, input string tag);
      item_t it;
      @(negedge clk);
      it.sel = s; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: state while reset is applied
      port(4, 8'h10, "R1 stat in reset");
      rst_n = 1'b1;
      rd(4'hF, 8'h10, "R1 stat after reset");
      rd(4'hE, 8'h00, "R1 ctl after reset");
      rd(4'h7, 8'h00, "R1 trim after reset");
      port(1, 8'h00, "R1 irq_oe after reset");

      wr(4'hE, 8'hC5);
      rd(4'hE, 8'hC5, "R9 ctl write");
      port(1, 8'h00, "R11 oe low while flag set");
      wr(4'h7, 8'hFF);
      rd(4'h7, 8'h7F, "R8 trim msb zero");
      port(2, 8'h7F, "R12 trim port");

      wr(4'hF, 8'hFF);
      rd(4'hF, 8'hBF, "R4 write one keeps flag, R7 write one no effect, R9");
      wr(4'hF, 8'hAF);
      rd(4'hF, 8'hAF, "R4 write zero clears flag");
      port(1, 8'h01, "R11 oe high after clear");
      wr(4'hE, 8'h05);
      port(1, 8'h00, "R11 oe low no enables");
      wr(4'hE, 8'h45);
      port(1, 8'h01, "R11 oe high day enable");

      wr(4'h3, 8'hFF);
      rd(4'h3, 8'h00, "R10 unmapped read");
      rd(4'h0, 8'h00, "R10 unmapped read 0");
      rd(4'hE, 8'h45, "R10 ctl untouched");
      rd(4'h7, 8'h7F, "R10 trim untouched");
      rd(4'hF, 8'hAF, "R10 stat untouched");

      op(4'h0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
      rd(4'hF, 8'hEF, "R7 drop sets flag");
      wr(4'hF, 8'hEF);
      rd(4'hF, 8'hEF, "R7 write one keeps");
      wr(4'hF, 8'hAF);
      rd(4'hF, 8'hAF, "R7 write zero clears");
      op(4'hF, 1'b1, 8'hAF, 1'b0, 1'b0, 1'b1);
      rd(4'hF, 8'hEF, "R7 input beats write");
      wr(4'hF, 8'hAF);

      op(4'h0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
      rd(4'hF, 8'h8F, "R6 stop clears osc bit");
      wr(4'hF, 8'h8F);
      rd(4'hF, 8'h8F, "R6 osc stays low");
      op(4'hF, 1'b1, 8'hAF, 1'b0, 1'b1, 1'b0);
      rd(4'hF, 8'h8F, "R6 stop beats write");
      wr(4'hF, 8'hAF);
      rd(4'hF, 8'hAF, "R6 write one restores");

      op(4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      rd(4'hF, 8'h30, "R3 stat cleared osc kept, R2 flag set");
      rd(4'hE, 8'h00, "R3 ctl cleared");
      rd(4'h7, 8'h00, "R3 trim cleared");
      port(1, 8'h00, "R11 oe low after event");
      repeat (3) @(negedge clk);
      rd(4'hF, 8'h30, "R2 flag held");
      wr(4'hF, 8'h30);
      port(4, 8'h30, "R4 write one keeps flag");

      wr(4'hE, 8'h80);
      wr(4'hF, 8'h20);
      port(1, 8'h01, "R11 oe high week enable");
      op(4'hF, 1'b1, 8'h2F, 1'b1, 1'b0, 1'b0);
      rd(4'hF, 8'h30, "R5 event beats clearing write");
      rd(4'hE, 8'h00, "R5 ctl cleared");
      port(1, 8'h00, "R5 R11 oe low");

      wr(4'hF, 8'h00);
      rd(4'hF, 8'h00, "R6 osc low flag cleared");
      wr(4'h7, 8'h12);
      port(2, 8'h12, "R12 trim port");
      op(4'h0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
      rd(4'hF, 8'h50, "R3 osc low kept, drop same cycle");
      port(2, 8'h00, "R3 trim port cleared");

      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule